// File: doc/BRIEF.md
# Serial EEPROM Configuration Image Programmer

This block writes a network controller's configuration image into a serial EEPROM and then checks the result. A word-level command port connects it to a downstream serial master, which handles the bit-level protocol. The block issues one read or write command at a time and waits for a response before it sends the next one. The image is never stored. Every word is recomputed from the latched station address, the fixed defaults and a checksum, whenever that word is needed.

A `start` pulse latches the 48-bit station address and the size selection. The block then spends one cycle per word summing every word except the last. This gives the checksum word, which makes the whole image add up to 0xBABA modulo 2^16. Next it writes each word, from address 0 upward. After that it reads each word back in the same order and compares it with the regenerated value. At the end, `done` rises and `fail` reports the outcome. Both flags hold until the next accepted start.

Top module: `eeprom_image_prog`

## Requirements
- R1: Address bytes are numbered so that byte k is `station_addr[8k+7:8k]`. Image word j, for j = 0, 1 and 2, carries byte 2j+1 in bits 15:8 and byte 2j in bits 7:0.
- R2: Word 10 is 0x40C0 and words 11 and 12 are 0x0000. Every other word below the last one is 0xFFFF.
- R3: The last word is 0xBABA minus the 16-bit wrapping sum of all earlier words, so the complete image sums to 0xBABA modulo 2^16.
- R4: With `wide_mode`=0 the image is 64 words (addresses 0 to 63). With `wide_mode`=1 it is 256 words (addresses 0 to 255).
- R5: Every word is written in ascending address order, and then every word is read in ascending order. A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both high. Only one command is outstanding until `rsp_valid` arrives, and the command fields stay stable while the block waits for `cmd_ready`.
- R6: If a read response differs from the expected word, the sequence stops at that word. No further commands are issued, and `done`=1 and `fail`=1.
- R7: If every read matches, the block ends with `done`=1, `fail`=0 and `busy`=0.
- R8: A response with `rsp_error`=1 aborts the sequence at once. No further commands are issued, and `done`=1 and `fail`=1.
- R9: `start` is accepted only while `busy`=0, and an accepted start clears `done` and `fail`. `station_addr` and `wide_mode` are latched when start is accepted, and later changes to them have no effect.
- R10: After reset, `busy`, `done`, `fail` and `cmd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a programming run (accepted only when idle) |
| station_addr | input | 48 | Station address; byte k at bits 8k+7:8k |
| wide_mode | input | 1 | 0: 64-word image, 1: 256-word image |
| cmd_valid | output | 1 | Command request to the serial master |
| cmd_ready | input | 1 | Serial master accepts the command |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | 8 | Word address |
| cmd_wdata | output | 16 | Write data |
| rsp_valid | input | 1 | Command completed (one-cycle pulse) |
| rsp_error | input | 1 | Command failed or timed out downstream |
| rsp_rdata | input | 16 | Read data, valid with `rsp_valid` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| fail | output | 1 | Run aborted or mismatch, valid with `done` |

## Verification
The assertions check the handshake rules on every cycle: fields held while the block waits for `cmd_ready`, a single outstanding command, the address range for the latched size, no command while idle, flag clearing on an accepted start, and the one-cycle abort when an error arrives. Only the bench scenarios can show the image contents. They show this by predicting every command in order and by summing the stored words to 0xBABA. They also cover stopping at the first corrupted read-back word, ignoring a second start and a changed address during a run, and running in both sizes.

// File: rtl/eeprom_image_prog.sv
module eeprom_image_prog #(
  parameter logic [15:0] SUM_TARGET = 16'hBABA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [47:0] station_addr,
  input  logic        wide_mode,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic        cmd_write,
  output logic [7:0]  cmd_addr,
  output logic [15:0] cmd_wdata,
  input  logic        rsp_valid,
  input  logic        rsp_error,
  input  logic [15:0] rsp_rdata,
  output logic        busy,
  output logic        done,
  output logic        fail
);
  typedef enum logic [2:0] {S_IDLE, S_SUM, S_WREQ, S_WWAIT, S_RREQ, S_RWAIT} st_t;
  st_t         st;
  logic [47:0] mac_q;
  logic        wide_q;
  logic [7:0]  idx;
  logic [15:0] acc, csum, word;
  logic [7:0]  last_idx;

  assign last_idx = wide_q ? 8'hFF : 8'h3F;

  always_comb begin
    if (idx == last_idx)                   word = csum;
    else if (idx < 8'd3)                   word = mac_q[{idx[1:0], 4'd0} +: 16];
    else if (idx == 8'd10)                 word = 16'h40C0;
    else if (idx == 8'd11 || idx == 8'd12) word = 16'h0000;
    else                                   word = 16'hFFFF;
  end

  assign busy      = (st != S_IDLE);
  assign cmd_valid = (st == S_WREQ) || (st == S_RREQ);
  assign cmd_write = (st == S_WREQ);
  assign cmd_addr  = idx;
  assign cmd_wdata = word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; mac_q <= '0; wide_q <= 1'b0; idx <= '0;
      acc <= '0; csum <= '0; done <= 1'b0; fail <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          mac_q <= station_addr; wide_q <= wide_mode;
          idx <= '0; acc <= '0; done <= 1'b0; fail <= 1'b0;
          st <= S_SUM;
        end
        S_SUM: begin
          acc <= acc + word;
          if (idx == last_idx - 8'd1) begin
            csum <= SUM_TARGET - (acc + word);
            idx  <= '0;
            st   <= S_WREQ;
          end else idx <= idx + 8'd1;
        end
        S_WREQ: if (cmd_ready) st <= S_WWAIT;
        S_WWAIT: if (rsp_valid) begin
          if (rsp_error) begin
            st <= S_IDLE; done <= 1'b1; fail <= 1'b1;
          end else if (idx == last_idx) begin
            idx <= '0; st <= S_RREQ;
          end else begin
            idx <= idx + 8'd1; st <= S_WREQ;
          end
        end
        S_RREQ: if (cmd_ready) st <= S_RWAIT;
        S_RWAIT: if (rsp_valid) begin
          if (rsp_error || rsp_rdata != word) begin
            st <= S_IDLE; done <= 1'b1; fail <= 1'b1;
          end else if (idx == last_idx) begin
            st <= S_IDLE; done <= 1'b1;
          end else begin
            idx <= idx + 8'd1; st <= S_RREQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_image_prog_chk.sv
module eeprom_image_prog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       wide_mode,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       cmd_write,
  input logic [7:0] cmd_addr,
  input logic [15:0] cmd_wdata,
  input logic       rsp_valid,
  input logic       rsp_error,
  input logic       busy,
  input logic       done,
  input logic       fail
);
  logic [1:0] outst;
  logic       wq;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst <= '0; wq <= 1'b0;
    end else begin
      if (start && !busy) wq <= wide_mode;
      outst <= outst + {1'b0, cmd_valid && cmd_ready} - {1'b0, rsp_valid};
    end
  end

  a_r5_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_write) && $stable(cmd_wdata));
  a_r5_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> outst == 2'd0);
  a_r4_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !wq |-> cmd_addr < 8'd64);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rsp_valid && rsp_error |=> !busy && done && fail);
  a_r9_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done && !fail);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind eeprom_image_prog eeprom_image_prog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
  .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
  .rsp_error(rsp_error), .busy(busy), .done(done), .fail(fail));

// File: tb/sim_eeprom_image_prog.sv
`timescale 1ns/1ps
module sim_eeprom_image_prog;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [47:0] station_addr = '0;
  logic wide_mode = 1'b0;
  logic cmd_valid, cmd_write, cmd_ready = 1'b0;
  logic [7:0] cmd_addr;
  logic [15:0] cmd_wdata;
  logic rsp_valid = 1'b0, rsp_error = 1'b0;
  logic [15:0] rsp_rdata = '0;
  logic busy, done, fail;

  always #4 clk = ~clk;

  eeprom_image_prog u0 (.*);

  int checks = 0, fails = 0, cycles = 0;
  logic [15:0] mem [256];
  logic [15:0] img [256];
  int n_words = 64;
  int cmd_n = 0;
  int lat = 0;
  int bad_addr = -1;
  int err_at = -1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic build_image(input logic [47:0] mac, input bit wide);
    logic [15:0] s;
    n_words = wide ? 256 : 64;
    s = 16'h0;
    for (int i = 0; i < n_words - 1; i++) begin
      if (i <= 2)                 img[i] = {mac[8*(2*i+1) +: 8], mac[8*(2*i) +: 8]};
      else if (i == 10)           img[i] = 16'h40C0;
      else if (i == 11 || i == 12) img[i] = 16'h0000;
      else                        img[i] = 16'hFFFF;
      s = s + img[i];
    end
    img[n_words-1] = 16'hBABA - s;
  endtask

  // downstream serial master model; compares each command with the predicted order
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid) begin
        bit ew; int ea; bit er;
        ew = (cmd_n < n_words);
        ea = cmd_n % n_words;
        chk(cmd_write == ew, "R5 command kind", cmd_write, ew);
        chk(cmd_addr == ea[7:0], "R4/R5 command address", cmd_addr, ea);
        if (ew) chk(cmd_wdata == img[ea], "R1/R2/R3 write data", cmd_wdata, img[ea]);
        er = (cmd_n == err_at);
        if (cmd_write) mem[cmd_addr] = cmd_wdata;
        rsp_rdata = mem[cmd_addr] ^ ((int'(cmd_addr) == bad_addr) ? 16'h0010 : 16'h0);
        cmd_n++;
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        repeat (lat) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_error = er;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_error = 1'b0;
      end
    end
  end

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        finish_sim();
      end
    end
  end

  task automatic run(input logic [47:0] mac, input bit wide, input int l, input int bad,
                     input int err, input bit exp_fail, input int exp_cmds, input bit poke);
    int t;
    build_image(mac, wide);
    lat = l; bad_addr = bad; err_at = err; cmd_n = 0;
    @(negedge clk);
    station_addr = mac; wide_mode = wide; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && !fail, "R9 start accepted, flags cleared", {busy, done, fail}, 3'b100);
    if (poke) begin
      station_addr = ~mac; wide_mode = ~wide;
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done && !busy, "R7 run completes", {done, busy}, 2'b10);
    chk(fail == exp_fail, exp_fail ? "R6/R8 fail flag" : "R7 fail flag", fail, exp_fail);
    chk(cmd_n == exp_cmds, exp_fail ? "R6/R8 no commands after stop" : "R5 command count",
        cmd_n, exp_cmds);
    if (!exp_fail) begin
      logic [15:0] s;
      s = 0;
      for (int i = 0; i < n_words; i++) s = s + mem[i];
      chk(s == 16'hBABA, "R3 stored image sum", s, 16'hBABA);
      chk(mem[1] == {mac[31:24], mac[23:16]}, "R1 word 1 byte order", mem[1], {mac[31:24], mac[23:16]});
      chk(mem[10] == 16'h40C0 && mem[12] == 16'h0, "R2 fixed words", {mem[10], mem[12]}, 32'h40C0_0000);
    end
    repeat (3) @(negedge clk);
    chk(!busy && done, "R9 second start ignored, no rerun", {busy, done}, 2'b01);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk({busy, done, fail, cmd_valid} == 4'b0, "R10 reset state", {busy, done, fail, cmd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, fail, cmd_valid} == 4'b0, "R10 idle after reset", {busy, done, fail, cmd_valid}, 0);
    run(48'h665544332211, 1'b0, 0, -1, -1, 1'b0, 128, 1'b0);
    run(48'h0FEDCBA98702, 1'b1, 3, -1, -1, 1'b0, 512, 1'b1);
    run(48'hA1B2C3D4E5F6, 1'b0, 1, 5, -1, 1'b1, 70, 1'b0);
    run(48'h123456789ABC, 1'b0, 0, -1, 10, 1'b1, 11, 1'b0);
    run(48'h123456789ABC, 1'b0, 2, -1, 100, 1'b1, 101, 1'b1);
    run(48'hFFFFFFFFFFFE, 1'b0, 0, 63, -1, 1'b1, 128, 1'b0);
    run(48'hFFFFFFFFFFFE, 1'b0, 0, -1, -1, 1'b0, 128, 1'b0);
    finish_sim();
  end
endmodule